// File: doc/BRIEF.md
# Ping-pong analog pipeline address controller

This controller drives the addresses and strobes for two banks of 48-cell sampled-analog pipeline memory. A bank cannot be written and read in the same period, so one bank records samples while the other is free for readout. On every beam-crossing tick the writing bank stores one sample in the next cell of its circular order. Each written cell also gets an 8-bit tag holding the crossing number. The two banks swap roles when a crossing tick carries the superbunch boundary marker. The high-gain and low-gain paths have their own pair of banks. Both pairs take the same address buses and enables.

When a level-1 accept arrives, the controller locates the triggered cell. That cell is the writing bank's next write address minus a programmable latency, counted in crossings, modulo 48. The accept is queued in a 4-entry FIFO. A queued event is read only after its bank has stopped writing, and only while the second-level buffer is not busy. The readout reads the peak cell and then the cell three crossings earlier, for baseline subtraction. After that it pulses a request carrying both cell addresses, the bank and the peak cell's tag, so the slower buffer can copy them.

Top module: `sca_pp_ctrl`

## Requirements
- R1: On a cycle with `xing_i` high, the next cycle shows exactly one `wr_en_o` bit set, for the writing bank (bit 0 = bank 0, bit 1 = bank 1). `wr_addr_o` holds that bank's pointer, which runs 0,1,…,47,0 for each bank on its own. `wr_tag_o` holds the crossing count: 8 bits, 0 after reset, plus one per tick, wrapping at 256.
- R2: No bank is read and written in the same cycle (`rd_en_o & wr_en_o` is always 0), and reads go only to the bank that is not writing.
- R3: A tick with `bnd_i` high is still written to the current bank. Ticks after it go to the other bank, which continues from its own pointer.
- R4: An accept (`acc_i` high) in a cycle records bank = current writing bank and peak = (that bank's next write address − `lat_i`) mod 48, with `lat_i` in 1..47. The event's readout does not start while its bank is still the writing bank.
- R5: A readout drives `rd_en_o` for the event's bank over two read cycles. The first cycle carries `rd_addr_o` = peak and the second carries (peak − 3) mod 48. These two cycles are back to back unless the bank becomes the writer in between. In that case the second read waits until the bank is free again.
- R6: In the cycle after the second read, `l2_req_o` pulses for one cycle. With it, `l2_bank_o`, `l2_peak_o`, `l2_base_o` and `l2_tag_o` carry the event's bank, peak address, baseline address and the peak cell's crossing tag. A new readout does not start in a cycle where `l2_busy_i` is high.
- R7: Accepts are served in arrival order. Up to 4 can wait, not counting one being served. An accept that finds 4 waiting, with none leaving in that cycle, is dropped and sets `acc_ovf_o`. The flag stays high until reset.
- R8: While `rst_ni` is low, all strobes, `l2_req_o` and `acc_ovf_o` are 0. After reset, both pointers and the crossing count are 0, bank 0 is the writer and the accept queue is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| xing_i | input | 1 | Beam-crossing tick, one cycle per crossing |
| bnd_i | input | 1 | Superbunch boundary, qualified by `xing_i` |
| acc_i | input | 1 | Level-1 accept |
| lat_i | input | 6 | Trigger latency in crossings (1..47) |
| wr_en_o | output | 2 | Write strobe per bank |
| wr_addr_o | output | 6 | Write cell address, shared by both banks |
| wr_tag_o | output | 8 | Crossing tag stored with the written cell |
| rd_en_o | output | 2 | Read strobe per bank |
| rd_addr_o | output | 6 | Read cell address, shared by both banks |
| l2_req_o | output | 1 | One-cycle copy request to the second-level buffer |
| l2_bank_o | output | 1 | Bank of the requested event |
| l2_peak_o | output | 6 | Peak cell address |
| l2_base_o | output | 6 | Baseline cell address |
| l2_tag_o | output | 8 | Crossing tag of the peak cell |
| l2_busy_i | input | 1 | Second-level buffer busy; holds off new readouts |
| acc_ovf_o | output | 1 | Sticky accept-queue overflow |

## Verification
Some properties are checked on every cycle: no bank is strobed for read and write together, each write strobe is one-hot with an address inside the 48 cells, a back-to-back read pair always steps back three cells, a request always follows a read, the overflow flag never falls, and the queue never pops when empty. Other behaviour shows only in the bench scenarios, which compare against a bench model of the requirements. These scenarios cover: a readout held back until its bank stops writing, the triggered-cell arithmetic and its wrap below cell 0, the tag values, arrival order through the queue, and the exact cycle in which the fifth waiting accept is dropped.

// File: rtl/sca_pkg.sv
package sca_pkg;
  localparam int unsigned CELLS = 48;
  localparam int unsigned AW    = $clog2(CELLS);
  localparam int unsigned TAGW  = 8;
  localparam int unsigned BANKS = 2;

  typedef logic [AW-1:0]   addr_t;
  typedef logic [TAGW-1:0] tag_t;

  typedef struct packed {
    logic  bank;
    addr_t peak;
  } acc_t;

  typedef enum logic [1:0] {RS_IDLE, RS_BASE, RS_REQ} rs_t;

  function automatic addr_t inc_mod(addr_t a);
    return (a == addr_t'(CELLS - 1)) ? '0 : a + 1'b1;
  endfunction

  function automatic addr_t sub_mod(addr_t a, addr_t b);
    int unsigned r;
    r = (32'(a) + CELLS - (32'(b) % CELLS)) % CELLS;
    return addr_t'(r);
  endfunction
endpackage

// File: rtl/sca_wr_ctrl.sv
module sca_wr_ctrl
  import sca_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             xing_i,
  input  logic             bnd_i,
  input  logic             tag_rd_bank_i,
  input  addr_t            tag_rd_addr_i,
  output tag_t             tag_rd_o,
  output logic             wr_bank_o,
  output addr_t            wr_ptr_o,
  output logic [BANKS-1:0] wr_en_o,
  output addr_t            wr_addr_o,
  output tag_t             wr_tag_o
);
  logic             wb_q;
  tag_t             xn_q;
  logic [BANKS-1:0] wr_en_q;
  addr_t            wr_addr_q;
  tag_t             wr_tag_q;
  addr_t            ptr_w [BANKS];
  tag_t             rd_w  [BANKS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wb_q      <= 1'b0;
      xn_q      <= '0;
      wr_en_q   <= '0;
      wr_addr_q <= '0;
      wr_tag_q  <= '0;
    end else begin
      wr_en_q <= '0;
      if (xing_i) begin
        wr_en_q[wb_q] <= 1'b1;
        wr_addr_q     <= ptr_w[wb_q];
        wr_tag_q      <= xn_q;
        xn_q          <= xn_q + 1'b1;
        if (bnd_i) wb_q <= ~wb_q;
      end
    end
  end

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    addr_t ptr_q;
    tag_t  cell_tag_q [CELLS];
    logic  sel;

    assign sel = xing_i && (wb_q == 1'(b));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ptr_q <= '0;
        for (int unsigned c = 0; c < CELLS; c++) cell_tag_q[c] <= '0;
      end else if (sel) begin
        cell_tag_q[ptr_q] <= xn_q;
        ptr_q             <= inc_mod(ptr_q);
      end
    end

    assign ptr_w[b] = ptr_q;
    assign rd_w[b]  = cell_tag_q[tag_rd_addr_i];
  end

  assign tag_rd_o  = rd_w[tag_rd_bank_i];
  assign wr_bank_o = wb_q;
  assign wr_ptr_o  = ptr_w[wb_q];
  assign wr_en_o   = wr_en_q;
  assign wr_addr_o = wr_addr_q;
  assign wr_tag_o  = wr_tag_q;

  assert_wr_onehot_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(wr_en_o))
    else $error("write strobe not one-hot");

  assert_wr_addr_range_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_o != '0) |-> (32'(wr_addr_o) < CELLS))
    else $error("write address outside cells");

  assert_wr_follows_tick_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_o != '0) |-> $past(xing_i))
    else $error("write strobe without tick");
endmodule

// File: rtl/sca_acc_fifo.sv
module sca_acc_fifo
  import sca_pkg::*;
#(
  parameter int unsigned DEPTH = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic push_i,
  input  acc_t din_i,
  input  logic pop_i,
  output acc_t dout_o,
  output logic empty_o,
  output logic ovf_o
);
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  acc_t          mem_q [DEPTH];
  logic [PW-1:0] rp_q, wp_q;
  logic [CW-1:0] cnt_q;
  logic          ovf_q, full, do_push, do_pop;

  function automatic logic [PW-1:0] nxt(logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign do_pop  = pop_i && !empty_o;
  assign do_push = push_i && (!full || do_pop);
  assign dout_o  = mem_q[rp_q];
  assign ovf_o   = ovf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rp_q  <= '0;
      wp_q  <= '0;
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      if (do_push) begin
        mem_q[wp_q] <= din_i;
        wp_q        <= nxt(wp_q);
      end
      if (do_pop) rp_q <= nxt(rp_q);
      if (do_push && !do_pop)      cnt_q <= cnt_q + 1'b1;
      else if (do_pop && !do_push) cnt_q <= cnt_q - 1'b1;
      if (push_i && full && !do_pop) ovf_q <= 1'b1;
    end
  end

  assert_no_pop_empty_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o)
    else $error("pop on empty queue");

  assert_ovf_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(ovf_o) |-> ovf_o)
    else $error("overflow flag fell");

  assert_count_range_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(cnt_q) <= DEPTH)
    else $error("queue count beyond depth");
endmodule

// File: rtl/sca_rd_seq.sv
module sca_rd_seq
  import sca_pkg::*;
#(
  parameter int unsigned BASE_OFS = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             empty_i,
  input  acc_t             head_i,
  input  tag_t             head_tag_i,
  input  logic             wr_bank_i,
  input  logic             l2_busy_i,
  output logic             pop_o,
  output logic [BANKS-1:0] rd_en_o,
  output addr_t            rd_addr_o,
  output logic             l2_req_o,
  output logic             l2_bank_o,
  output addr_t            l2_peak_o,
  output addr_t            l2_base_o,
  output tag_t             l2_tag_o
);
  rs_t              st_q;
  acc_t             ev_q;
  tag_t             tag_q;
  addr_t            base_q;
  logic [BANKS-1:0] rd_en_q;
  addr_t            rd_addr_q;
  logic             req_q;
  logic             start;

  // head may start only once its bank has stopped writing
  assign start = (st_q == RS_IDLE) && !empty_i && (head_i.bank != wr_bank_i) && !l2_busy_i;
  assign pop_o = start;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= RS_IDLE;
      ev_q      <= '0;
      tag_q     <= '0;
      base_q    <= '0;
      rd_en_q   <= '0;
      rd_addr_q <= '0;
      req_q     <= 1'b0;
    end else begin
      rd_en_q <= '0;
      req_q   <= 1'b0;
      case (st_q)
        RS_IDLE: if (start) begin
          rd_en_q[head_i.bank] <= 1'b1;
          rd_addr_q            <= head_i.peak;
          ev_q                 <= head_i;
          tag_q                <= head_tag_i;
          st_q                 <= RS_BASE;
        end
        RS_BASE: if (ev_q.bank != wr_bank_i) begin
          rd_en_q[ev_q.bank] <= 1'b1;
          rd_addr_q          <= sub_mod(ev_q.peak, addr_t'(BASE_OFS));
          base_q             <= sub_mod(ev_q.peak, addr_t'(BASE_OFS));
          st_q               <= RS_REQ;
        end
        RS_REQ: begin
          req_q <= 1'b1;
          st_q  <= RS_IDLE;
        end
        default: st_q <= RS_IDLE;
      endcase
    end
  end

  assign rd_en_o   = rd_en_q;
  assign rd_addr_o = rd_addr_q;
  assign l2_req_o  = req_q;
  assign l2_bank_o = ev_q.bank;
  assign l2_peak_o = ev_q.peak;
  assign l2_base_o = base_q;
  assign l2_tag_o  = tag_q;

  assert_base_follows_peak_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_o != '0 && $past(rd_en_o) != '0) |->
      (rd_en_o == $past(rd_en_o) && rd_addr_o == sub_mod($past(rd_addr_o), addr_t'(BASE_OFS))))
    else $error("baseline read not three cells before peak");

  assert_req_after_read_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    l2_req_o |-> ($past(rd_en_o) != '0))
    else $error("request without preceding read");

  assert_req_single_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    l2_req_o |=> !l2_req_o)
    else $error("request longer than one cycle");
endmodule

// File: rtl/sca_pp_ctrl.sv
module sca_pp_ctrl
  import sca_pkg::*;
#(
  parameter int unsigned QDEPTH   = 4,
  parameter int unsigned BASE_OFS = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            xing_i,
  input  logic            bnd_i,
  input  logic            acc_i,
  input  logic [AW-1:0]   lat_i,
  output logic [1:0]      wr_en_o,
  output logic [AW-1:0]   wr_addr_o,
  output logic [TAGW-1:0] wr_tag_o,
  output logic [1:0]      rd_en_o,
  output logic [AW-1:0]   rd_addr_o,
  output logic            l2_req_o,
  output logic            l2_bank_o,
  output logic [AW-1:0]   l2_peak_o,
  output logic [AW-1:0]   l2_base_o,
  output logic [TAGW-1:0] l2_tag_o,
  input  logic            l2_busy_i,
  output logic            acc_ovf_o
);
  logic  wr_bank, empty, pop;
  addr_t wr_ptr;
  acc_t  push_d, head;
  tag_t  head_tag;

  assign push_d.bank = wr_bank;
  assign push_d.peak = sub_mod(wr_ptr, lat_i);

  sca_wr_ctrl u_wr (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .xing_i        (xing_i),
    .bnd_i         (bnd_i),
    .tag_rd_bank_i (head.bank),
    .tag_rd_addr_i (head.peak),
    .tag_rd_o      (head_tag),
    .wr_bank_o     (wr_bank),
    .wr_ptr_o      (wr_ptr),
    .wr_en_o       (wr_en_o),
    .wr_addr_o     (wr_addr_o),
    .wr_tag_o      (wr_tag_o)
  );

  sca_acc_fifo #(.DEPTH(QDEPTH)) u_q (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (acc_i),
    .din_i   (push_d),
    .pop_i   (pop),
    .dout_o  (head),
    .empty_o (empty),
    .ovf_o   (acc_ovf_o)
  );

  sca_rd_seq #(.BASE_OFS(BASE_OFS)) u_rd (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .empty_i    (empty),
    .head_i     (head),
    .head_tag_i (head_tag),
    .wr_bank_i  (wr_bank),
    .l2_busy_i  (l2_busy_i),
    .pop_o      (pop),
    .rd_en_o    (rd_en_o),
    .rd_addr_o  (rd_addr_o),
    .l2_req_o   (l2_req_o),
    .l2_bank_o  (l2_bank_o),
    .l2_peak_o  (l2_peak_o),
    .l2_base_o  (l2_base_o),
    .l2_tag_o   (l2_tag_o)
  );

  assert_no_bank_clash_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_o & wr_en_o) == 2'b00)
    else $error("bank read and written together");

  assert_read_one_bank_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(rd_en_o))
    else $error("both banks read");

  assert_req_addr_range_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    l2_req_o |-> (32'(l2_peak_o) < CELLS && 32'(l2_base_o) < CELLS))
    else $error("requested cell outside bank");
endmodule

// File: tb/sca_pp_ctrl_tb_top.sv
module sca_pp_ctrl_tb_top;
  import sca_pkg::*;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic rst_ni, xing, bnd, acc, busy;
  logic [AW-1:0] lat;
  logic [1:0] wr_en, rd_en;
  logic [AW-1:0] wr_addr, rd_addr, l2_peak, l2_base;
  logic [TAGW-1:0] wr_tag, l2_tag;
  logic l2_req, l2_bank, ovf;

  sca_pp_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .xing_i(xing), .bnd_i(bnd), .acc_i(acc), .lat_i(lat),
    .wr_en_o(wr_en), .wr_addr_o(wr_addr), .wr_tag_o(wr_tag),
    .rd_en_o(rd_en), .rd_addr_o(rd_addr),
    .l2_req_o(l2_req), .l2_bank_o(l2_bank), .l2_peak_o(l2_peak), .l2_base_o(l2_base),
    .l2_tag_o(l2_tag), .l2_busy_i(busy), .acc_ovf_o(ovf)
  );

  int n_chk = 0, n_err = 0;

  // model of the requirements
  int m_wb, m_x, q_n, m_ovf, rs, ev_b, ev_p, ev_t;
  int m_ptr [2];
  int m_tag [2][48];
  int q_b [4];
  int q_p [4];

  task automatic check(input string r, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  task automatic model_reset();
    m_wb = 0; m_x = 0; q_n = 0; m_ovf = 0; rs = 0; ev_b = 0; ev_p = 0; ev_t = 0;
    m_ptr[0] = 0; m_ptr[1] = 0;
    for (int b = 0; b < 2; b++) for (int c = 0; c < 48; c++) m_tag[b][c] = 0;
  endtask

  // called at a negedge; drives inputs, returns at the next negedge after checking
  task automatic step(input bit x, input bit bd, input bit a, input bit bz, input int l);
    int e_wen, e_wa, e_wt, e_ren, e_ra, e_req, e_b, e_p, e_bs, e_t, pop, pk;
    xing = x; bnd = bd; acc = a; busy = bz; lat = AW'(l);
    e_wen = x ? (1 << m_wb) : 0; e_wa = m_ptr[m_wb]; e_wt = m_x;
    e_ren = 0; e_ra = 0; e_req = 0; pop = 0;
    e_b = ev_b; e_p = ev_p; e_bs = (ev_p + 45) % 48; e_t = ev_t;
    case (rs)
      0: if (q_n > 0 && q_b[0] != m_wb && !bz) begin
        e_ren = 1 << q_b[0]; e_ra = q_p[0];
        ev_b = q_b[0]; ev_p = q_p[0]; ev_t = m_tag[ev_b][ev_p];
        pop = 1; rs = 1;
      end
      1: if (ev_b != m_wb) begin
        e_ren = 1 << ev_b; e_ra = (ev_p + 45) % 48; rs = 2;
      end
      default: begin e_req = 1; rs = 0; end
    endcase
    if (pop == 1) begin
      for (int i = 0; i < 3; i++) begin q_b[i] = q_b[i+1]; q_p[i] = q_p[i+1]; end
      q_n--;
    end
    if (a) begin
      pk = (m_ptr[m_wb] + 48 - l) % 48;
      if (q_n < 4) begin q_b[q_n] = m_wb; q_p[q_n] = pk; q_n++; end
      else m_ovf = 1;
    end
    if (x) begin
      m_tag[m_wb][m_ptr[m_wb]] = m_x;
      m_ptr[m_wb] = (m_ptr[m_wb] + 1) % 48;
      m_x = (m_x + 1) % 256;
      if (bd) m_wb ^= 1;
    end
    @(negedge clk);
    check("R1 R3 wr_en", 32'(wr_en), e_wen);
    if (e_wen != 0) begin
      check("R1 wr_addr", 32'(wr_addr), e_wa);
      check("R1 wr_tag", 32'(wr_tag), e_wt);
    end
    check("R2 no clash", 32'(rd_en & wr_en), 0);
    check("R4 R5 rd_en", 32'(rd_en), e_ren);
    if (e_ren != 0) check("R5 rd_addr", 32'(rd_addr), e_ra);
    check("R6 l2_req", 32'(l2_req), e_req);
    if (e_req != 0) begin
      check("R4 l2_bank", 32'(l2_bank), e_b);
      check("R4 l2_peak", 32'(l2_peak), e_p);
      check("R5 l2_base", 32'(l2_base), e_bs);
      check("R6 l2_tag", 32'(l2_tag), e_t);
    end
    check("R7 ovf", 32'(ovf), m_ovf);
  endtask

  task automatic do_reset();
    rst_ni = 1'b0; xing = 0; bnd = 0; acc = 0; busy = 0; lat = AW'(1);
    model_reset();
    @(negedge clk);
    @(negedge clk);
    check("R8 wr_en", 32'(wr_en), 0);
    check("R8 rd_en", 32'(rd_en), 0);
    check("R8 l2_req", 32'(l2_req), 0);
    check("R8 ovf", 32'(ovf), 0);
    rst_ni = 1'b1;
  endtask

  task automatic rand_run(input int n);
    for (int i = 0; i < n; i++) begin
      bit x, bd, a, bz;
      x  = ($urandom % 3) == 0;
      bd = x && (($urandom % 12) == 0);
      a  = ($urandom % 30) == 0;
      bz = ($urandom % 8) == 0;
      step(x, bd, a, bz, 1 + int'($urandom % 47));
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_err++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    void'($urandom(32'd20001));
    @(negedge clk);
    do_reset();

    // R4 wrap below cell 0, readout held until bank 0 stops writing (R3)
    step(1, 0, 0, 0, 1);
    step(1, 0, 0, 0, 1);
    step(0, 0, 1, 0, 2);            // peak 0, base 45
    for (int i = 0; i < 4; i++) step(0, 0, 0, 0, 2);
    step(1, 1, 0, 0, 2);            // swap: bank 1 writes
    for (int i = 0; i < 6; i++) step(0, 0, 0, 0, 2);
    step(1, 0, 0, 0, 2);            // bank 1 cell 0

    // R6 busy hold-off
    step(1, 1, 0, 0, 2);            // back to bank 0
    step(0, 0, 1, 1, 5);
    step(1, 1, 0, 1, 5);
    for (int i = 0; i < 4; i++) step(0, 0, 0, 1, 5);
    for (int i = 0; i < 5; i++) step(0, 0, 0, 0, 5);

    rand_run(6000);

    // R7 overflow on the fifth waiting accept, then order of service
    do_reset();
    for (int i = 1; i <= 5; i++) step(0, 0, 1, 1, i);
    step(1, 1, 0, 0, 1);
    for (int i = 0; i < 20; i++) step(0, 0, 0, 0, 1);

    // R8 reset clears sticky flag
    do_reset();
    step(1, 0, 0, 0, 1);
    rand_run(3000);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule